// File: doc/BRIEF.md
# DRAM Bank Activation Timing Guard

This block watches the command bus between a memory controller's scheduler and an eight-bank DDR2-style DRAM. On every rising clock edge it decodes the chip-select, RAS#, CAS# and WE# levels. It recognises activate and precharge commands and keeps a record of which banks hold an open row and which row each one holds. It also keeps saturating cycle counters per bank and for the whole device. From these it presents two flag vectors:

- `act_ok` marks, per bank, whether an activate issued on the next edge would respect every row timing rule.
- `pre_ok` marks, per bank, whether a precharge on the next edge would respect the minimum open time.

The scheduler can read both flags before it commits a command. If a command breaks a rule anyway, a sticky error output rises. The command is still applied to the bank state, so tracking stays aligned with the real device.

Every timing limit is an input given in whole clocks. Besides the usual per-bank row rules, the block enforces two further limits. No more than four activates may fall in any rolling window of `t_faw` clocks. After a precharge-all, each closed bank must wait one clock longer than a single-bank precharge requires.

Top module: `act_timing_guard`

## Requirements
- R1: An activate is decoded at a rising edge when cs_n=0, ras_n=0, cas_n=1, we_n=1. It sets `bank_open[ba]` on that edge and stores `addr` as that bank's row in `open_rows[ba*14 +: 14]`.
- R2: A precharge is decoded when cs_n=0, ras_n=0, cas_n=1, we_n=0. With addr[10]=0 it closes bank `ba` only. With addr[10]=1 it closes every open bank.
- R3: `act_ok[b]` is 0 while bank b is open. An activate to an open bank sets `err`.
- R4: An activate to bank b is allowed only when at least `t_rc` clock edges have passed since the previous activate to bank b.
- R5: An activate is allowed only when at least `t_rrd` edges have passed since the last activate to a different bank.
- R6: `pre_ok[b]` stays 0 until bank b has been open for `t_ras` edges. A single-bank precharge issued earlier, or a precharge-all issued while any open bank is younger than that, sets `err`.
- R7: After a single-bank precharge, bank b may be reactivated only once `t_rp` edges have passed.
- R8: After a precharge-all, each bank it closed may be reactivated only once `t_rp`+1 edges have passed.
- R9: An activate is allowed only if the fourth-most-recent activate lies at least `t_faw` edges in the past. So at most four activates fall in any `t_faw` window.
- R10: `err` is sticky and is cleared only by reset. A violating command still updates the bank state.
- R11: After reset, all banks are closed, `act_ok` and `pre_ok` are all ones and `err` is 0.
- R12: Edges with cs_n=1 have no effect. Neither do read, write or other non-activate, non-precharge encodings, or a precharge to a bank that is already closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe level |
| cas_n | input | 1 | Column strobe level |
| we_n | input | 1 | Write enable level |
| ba | input | 3 | Bank address |
| addr | input | 14 | Row address; bit 10 selects precharge-all |
| t_rc | input | 6 | Min edges between activates to the same bank |
| t_rrd | input | 6 | Min edges between activates to different banks |
| t_ras | input | 6 | Min edges from activate to precharge |
| t_rp | input | 6 | Min edges from single precharge to activate |
| t_faw | input | 6 | Rolling four-activate window length |
| act_ok | output | 8 | Per-bank: activate on next edge is legal |
| pre_ok | output | 8 | Per-bank: precharge on next edge is legal |
| bank_open | output | 8 | Per-bank open state |
| open_rows | output | 112 | Open row per bank, 14 bits each, bank 0 lowest |
| err | output | 1 | Sticky timing violation flag |

## Verification
The bench places each rule exactly on its boundary. It samples the allow flags one clock before the limit and then on the limit itself. An off-by-one counter would show up as a flag that rises a cycle early or late.

The precharge-all test runs against a single precharge with the same `t_rp`. A design that dropped the extra clock would raise `act_ok` at `t_rp` instead of `t_rp`+1.

The four-activate window is filled with back-to-back activates. The bench checks that the fifth is refused until exactly `t_faw` edges after the first. It then checks that the sixth opens at once, which only happens if the window rolls rather than resets.

Violation tests confirm that `err` sticks and that a refused activate still marks its bank open. Ignore tests drive deselected and column commands, which a loose decoder would mistake for row commands.

// File: rtl/act_timing_guard.sv
module act_timing_guard #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int CNT_W     = 6,
  parameter int FAW_N     = 4,
  parameter int ALL_BIT   = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  input  logic [CNT_W-1:0]           t_rc,
  input  logic [CNT_W-1:0]           t_rrd,
  input  logic [CNT_W-1:0]           t_ras,
  input  logic [CNT_W-1:0]           t_rp,
  input  logic [CNT_W-1:0]           t_faw,
  output logic [NUM_BANKS-1:0]       act_ok,
  output logic [NUM_BANKS-1:0]       pre_ok,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       err
);

  localparam logic [CNT_W-1:0] SAT = '1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == SAT) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] since_any;
  logic [BA_W-1:0]  last_ba;
  logic [CNT_W-1:0] faw_age [FAW_N];
  logic             err_q;

  wire is_act  = !cs_n && !ras_n &&  cas_n &&  we_n;
  wire is_pre  = !cs_n && !ras_n &&  cas_n && !we_n;
  wire pre_all = is_pre &&  addr[ALL_BIT];
  wire pre_one = is_pre && !addr[ALL_BIT];
  wire faw_ok  = faw_age[FAW_N-1] >= t_faw;

  wire bad_act = is_act && !act_ok[ba];
  wire bad_pre = (pre_one && !pre_ok[ba]) || (pre_all && !(&pre_ok));

  assign err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q     <= 1'b0;
      since_any <= SAT;
      last_ba   <= '0;
    end else begin
      err_q <= err_q | bad_act | bad_pre;
      if (is_act) begin
        since_any <= CNT_W'(1);
        last_ba   <= ba;
      end else begin
        since_any <= bump(since_any);
      end
    end
  end

  for (genvar i = 0; i < FAW_N; i++) begin : g_faw
    always_ff @(posedge clk) begin
      if (!rst_n)
        faw_age[i] <= SAT;
      else if (is_act)
        faw_age[i] <= (i == 0) ? CNT_W'(1) : bump(faw_age[(i == 0) ? 0 : i-1]);
      else
        faw_age[i] <= bump(faw_age[i]);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] since_act, since_pre;
    logic             open_q, pall_q;
    logic [ROW_W-1:0] row_q;

    wire sel     = (ba == BA_W'(b));
    wire act_b   = is_act && sel;
    wire close_b = open_q && ((pre_one && sel) || pre_all);
    wire [CNT_W:0] rp_need = {1'b0, t_rp} + (CNT_W+1)'(pall_q);
    wire rrd_ok  = (last_ba == BA_W'(b)) || (since_any >= t_rrd);

    assign act_ok[b] = !open_q && (since_act >= t_rc) &&
                       ({1'b0, since_pre} >= rp_need) && rrd_ok && faw_ok;
    assign pre_ok[b] = !open_q || (since_act >= t_ras);
    assign bank_open[b] = open_q;
    assign open_rows[b*ROW_W +: ROW_W] = row_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        since_act <= SAT;
        since_pre <= SAT;
        open_q    <= 1'b0;
        pall_q    <= 1'b0;
        row_q     <= '0;
      end else begin
        since_act <= act_b   ? CNT_W'(1) : bump(since_act);
        since_pre <= close_b ? CNT_W'(1) : bump(since_pre);
        if (act_b) begin
          open_q <= 1'b1;
          pall_q <= 1'b0;
          row_q  <= addr;
        end else if (close_b) begin
          open_q <= 1'b0;
          pall_q <= pre_all;
        end
      end
    end
  end

endmodule

// File: rtl/act_timing_guard_chk.sv
module act_timing_guard_chk #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int CNT_W     = 6,
  parameter int ALL_BIT   = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
)(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n,
  input logic                       ras_n,
  input logic                       cas_n,
  input logic                       we_n,
  input logic [BA_W-1:0]            ba,
  input logic [ROW_W-1:0]           addr,
  input logic [NUM_BANKS-1:0]       act_ok,
  input logic [NUM_BANKS-1:0]       bank_open,
  input logic                       err
);

  wire c_act = !cs_n && !ras_n && cas_n &&  we_n;
  wire c_pre = !cs_n && !ras_n && cas_n && !we_n;

  // R1
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_act |=> bank_open[$past(ba)]);

  // R2
  pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pre && addr[ALL_BIT]) |=> (bank_open == '0));

  // R2
  pre_one_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pre && !addr[ALL_BIT]) |=> !bank_open[$past(ba)]);

  // R3
  no_act_ok_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ok & bank_open) == '0);

  // R3
  bad_act_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_act && !act_ok[ba]) |=> err);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R12
  deselect_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(bank_open));

endmodule

bind act_timing_guard act_timing_guard_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .CNT_W(CNT_W), .ALL_BIT(ALL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .act_ok(act_ok),
  .bank_open(bank_open), .err(err)
);

// File: tb/tb_act_timing_guard.sv
module tb_act_timing_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0;
  logic [13:0] addr = '0;
  logic [5:0]  t_rc = 6'd1, t_rrd = 6'd1, t_ras = 6'd1, t_rp = 6'd1, t_faw = 6'd1;
  logic [7:0]  act_ok, pre_ok, bank_open;
  logic [111:0] open_rows;
  logic err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  act_timing_guard dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .t_rc(t_rc), .t_rrd(t_rrd),
    .t_ras(t_ras), .t_rp(t_rp), .t_faw(t_faw), .act_ok(act_ok),
    .pre_ok(pre_ok), .bank_open(bank_open), .open_rows(open_rows), .err(err)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic setup(input int rc, input int rrd, input int ras, input int rp, input int faw);
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1;
    t_rc = 6'(rc); t_rrd = 6'(rrd); t_ras = 6'(ras); t_rp = 6'(rp); t_faw = 6'(faw);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic issue(input logic c, input logic r, input logic ca, input logic w,
                       input logic [2:0] b, input logic [13:0] a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    @(negedge clk);
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic act(input logic [2:0] b, input logic [13:0] row);
    issue(1'b0, 1'b0, 1'b1, 1'b1, b, row);
  endtask

  task automatic pre(input logic [2:0] b);
    issue(1'b0, 1'b0, 1'b1, 1'b0, b, 14'h0000);
  endtask

  task automatic prea();
    issue(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 14'h0400);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic t_reset_state();
    setup(1, 1, 1, 1, 1);
    check("R11 open", 32'(bank_open), 32'h00);
    check("R11 act_ok", 32'(act_ok), 32'hFF);
    check("R11 pre_ok", 32'(pre_ok), 32'hFF);
    check("R11 err", 32'(err), 32'h0);
  endtask

  task automatic t_open_and_rrd();
    setup(1, 3, 1, 1, 1);
    act(3'd2, 14'h1ABC);
    check("R1 open", 32'(bank_open), 32'h04);
    check("R1 row", 32'(open_rows[2*14 +: 14]), 32'h1ABC);
    check("R3 act_ok open", 32'(act_ok[2]), 32'h0);
    check("R5 gap1", 32'(act_ok[5]), 32'h0);
    idle(1);
    check("R5 gap2", 32'(act_ok[5]), 32'h0);
    idle(1);
    check("R5 gap3", 32'(act_ok[5]), 32'h1);
  endtask

  task automatic t_ras_rule();
    setup(1, 1, 8, 1, 1);
    act(3'd2, 14'h0011);
    idle(6);
    check("R6 gap7", 32'(pre_ok[2]), 32'h0);
    idle(1);
    check("R6 gap8", 32'(pre_ok[2]), 32'h1);
    pre(3'd2);
    check("R2 single close", 32'(bank_open), 32'h00);
    check("R6 legal pre err", 32'(err), 32'h0);
  endtask

  task automatic t_rp_rule();
    setup(1, 1, 1, 4, 1);
    act(3'd1, 14'h0022);
    act(3'd3, 14'h0033);
    pre(3'd1);
    check("R2 only selected", 32'(bank_open), 32'h08);
    idle(2);
    check("R7 gap3", 32'(act_ok[1]), 32'h0);
    idle(1);
    check("R7 gap4", 32'(act_ok[1]), 32'h1);
  endtask

  task automatic t_rc_rule();
    setup(12, 1, 2, 1, 1);
    act(3'd3, 14'h0044);
    idle(1);
    pre(3'd3);
    idle(8);
    check("R4 gap11", 32'(act_ok[3]), 32'h0);
    idle(1);
    check("R4 gap12", 32'(act_ok[3]), 32'h1);
  endtask

  task automatic t_prea_rule();
    setup(1, 1, 1, 4, 1);
    act(3'd0, 14'h0055);
    act(3'd6, 14'h0066);
    prea();
    check("R2 all closed", 32'(bank_open), 32'h00);
    idle(2);
    check("R8 gap3", 32'(act_ok[0]), 32'h0);
    check("R8 untouched bank", 32'(act_ok[4]), 32'h1);
    idle(1);
    check("R8 gap4 b0", 32'(act_ok[0]), 32'h0);
    check("R8 gap4 b6", 32'(act_ok[6]), 32'h0);
    idle(1);
    check("R8 gap5", 32'(act_ok[0]), 32'h1);
    check("R8 no err", 32'(err), 32'h0);
  endtask

  task automatic t_faw_rule();
    setup(1, 1, 1, 1, 10);
    act(3'd0, 14'h0001);
    act(3'd1, 14'h0002);
    act(3'd2, 14'h0003);
    act(3'd3, 14'h0004);
    check("R9 fifth gap4", 32'(act_ok[4]), 32'h0);
    idle(5);
    check("R9 fifth gap9", 32'(act_ok[4]), 32'h0);
    idle(1);
    check("R9 fifth gap10", 32'(act_ok[4]), 32'h1);
    act(3'd4, 14'h0005);
    check("R9 rolling next", 32'(act_ok[5]), 32'h1);
    check("R9 no err", 32'(err), 32'h0);
  endtask

  task automatic t_violations();
    setup(1, 3, 1, 1, 1);
    act(3'd0, 14'h0007);
    act(3'd1, 14'h0008);
    check("R10 err set", 32'(err), 32'h1);
    check("R10 still tracked", 32'(bank_open), 32'h03);
    idle(4);
    check("R10 sticky", 32'(err), 32'h1);
    setup(1, 1, 1, 1, 1);
    check("R10 reset clears", 32'(err), 32'h0);
    act(3'd2, 14'h0009);
    act(3'd2, 14'h000A);
    check("R3 act to open", 32'(err), 32'h1);
    setup(1, 1, 8, 1, 1);
    act(3'd5, 14'h000B);
    pre(3'd5);
    check("R6 early pre err", 32'(err), 32'h1);
    check("R6 early pre closes", 32'(bank_open), 32'h00);
  endtask

  task automatic t_ignored();
    setup(1, 1, 1, 1, 1);
    issue(1'b1, 1'b0, 1'b1, 1'b1, 3'd3, 14'h0100);
    check("R12 deselected", 32'(bank_open), 32'h00);
    issue(1'b0, 1'b1, 1'b0, 1'b1, 3'd3, 14'h0000);
    check("R12 read", 32'(bank_open), 32'h00);
    issue(1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 14'h0000);
    check("R12 refresh code", 32'(bank_open), 32'h00);
    act(3'd3, 14'h0123);
    issue(1'b0, 1'b1, 1'b0, 1'b0, 3'd3, 14'h0400);
    check("R12 write keeps open", 32'(bank_open), 32'h08);
    pre(3'd5);
    check("R12 pre closed bank", 32'(bank_open), 32'h08);
    check("R12 no err", 32'(err), 32'h0);
    check("R12 row kept", 32'(open_rows[3*14 +: 14]), 32'h0123);
  endtask

  initial begin
    t_reset_state();
    t_open_and_rrd();
    t_ras_rule();
    t_rp_rule();
    t_rc_rule();
    t_prea_rule();
    t_faw_rule();
    t_violations();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule